// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a byte-wide serial memory of 1024 locations on a two-wire bus. The bus lines are brought into the system clock domain through two-flop synchronisers. Start and stop conditions and clock edges are found on the synchronised samples. The engine takes the device address byte and compares it with a fixed prefix and one strap pin. It acknowledges by pulling SDA low through an open-drain output enable. It then performs a byte write, a current-address read, a random read (a dummy write followed by a repeated start) or a sequential read against an internal synchronous RAM model.

A byte write only reaches the array when the stop condition arrives. One shared address counter records where the last access ended. That counter is used by current-address reads and sequential reads, and it wraps from the top of the array back to location 0. Page buffering and the write-cycle timer belong to a separate block.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start; a rising SDA while SCL is high is a stop. A start at any point abandons the transaction in progress, releases SDA and restarts address reception with the bit counter cleared.
- R2: The first byte after a start is taken MSB first. It is acknowledged only if bits 7:4 equal 1010 and bit 3 equals `a2_strap`. On a mismatch the slave gives no ACK and ignores the bus until the next start, which leaves the memory unchanged.
- R3: A write consists of an address byte with bit 0 = 0, a word-address byte and a data byte, and each is acknowledged in the ninth clock. The data reaches the array only when a stop follows. A repeated start in place of the stop discards it.
- R4: A read address byte (bit 0 = 1) without a preceding word address returns the byte at {address-byte bits 2:1, low eight bits of the counter}. The counter holds the last accessed location plus one, after both writes and reads.
- R5: A write-mode address byte and a word-address byte, then a repeated start with a read-mode address byte, return the byte at {bits 2:1, word address}.
- R6: Each master ACK after a read byte makes the slave send the byte at the next location. The location after 1023 is 0.
- R7: After a master NACK the slave keeps SDA released for all further clocks until a start or stop.
- R8: SDA output changes only after a synchronised SCL falling edge or a start/stop. Read data leaves MSB first, and SDA is released during the master's acknowledge clock.
- R9: After reset SDA is released, and clocked bits that are not preceded by a start get no acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| a2_strap | input | 1 | Strap value compared with address-byte bit 3 |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
In a read, a single SCL falling edge does two jobs. It ends the slave's own acknowledge of the address byte, and it puts the most significant data bit on the line. Both must resolve in the same system clock. Reads of bytes whose MSB is 0 after an acknowledge, and of bytes whose MSB is 1, show whether the ACK drive lingers or the first bit arrives late. Each is judged by the byte value the master clocks in. The case of a pending write meeting a repeated start in place of a stop is judged by a later read showing the old content.

// File: rtl/twi_eeprom_pkg.sv
// Shared types for the two-wire memory slave.
package twi_eeprom_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_DEV,    // receiving the address byte
        ST_ACK,    // slave acknowledge clock
        ST_WORD,   // receiving the word address
        ST_DATA,   // receiving the write data
        ST_TX,     // shifting read data out
        ST_MACK,   // master acknowledge clock after read data
        ST_HOLD    // released, waiting for start or stop
    } slv_state_t;
endpackage

// File: rtl/twi_bus_sampler.sv
// Brings SCL and SDA into the clk domain and flags edges and bus conditions.
// Assumes SCL high and low phases each last several clk cycles.
module twi_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    // Synchroniser chains plus one delayed copy for edge detection; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Edge and condition decode on the synchronised samples.
    always_comb begin
        scl_s     = scl_pipe[SYNC_STAGES-1];
        sda_s     = sda_pipe[SYNC_STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/twi_byte_ram.sv
// Simple synchronous RAM model: one write port, registered read port.
// Assumes the read address is stable at least one clk before data is used.
module twi_byte_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    logic [DATA_W-1:0] mem [DEPTH];

    // Write on request, read every cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/twi_eeprom_slave.sv
// Two-wire memory slave: address match, ACK, byte write committed at stop,
// current/random/sequential read from a wrapping shared address counter.
// Assumes ADDR_W - 8 equals the number of block-select bits in the address byte (2).
module twi_eeprom_slave #(
    parameter int         ADDR_W      = 10,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic a2_strap,
    output logic sda_oe
);
    import twi_eeprom_pkg::*;

    localparam int BLK_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    slv_state_t state, nxt;
    logic [2:0]        bitcnt;
    logic [7:0]        shreg, tx, rd_q, wr_data;
    logic [ADDR_W-1:0] cnt, wr_addr;
    logic [BLK_W-1:0]  blk_q;
    logic              ack_on, pend, ram_we, more;
    logic [7:0]        rx_byte;
    logic              byte_done;

    twi_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_byte_ram #(.ADDR_W(ADDR_W), .DATA_W(8)) u_ram (
        .clk(clk), .we(ram_we), .waddr(wr_addr), .wdata(wr_data),
        .raddr(cnt), .rdata(rd_q)
    );

    // Incoming byte as it will look after the current rising edge.
    always_comb begin
        rx_byte   = {shreg[6:0], sda_s};
        byte_done = scl_rise && (bitcnt == 3'd7);
    end

    // Transaction state machine and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            nxt     <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            cnt     <= '0;
            blk_q   <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            pend    <= 1'b0;
            ram_we  <= 1'b0;
            ack_on  <= 1'b0;
            more    <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            ram_we <= 1'b0;
            if (start_det) begin
                state  <= ST_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                pend   <= 1'b0;
                ack_on <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
                ram_we <= pend;
                pend   <= 1'b0;
                ack_on <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV, ST_WORD, ST_DATA: begin
                        if (scl_rise) begin
                            shreg  <= rx_byte;
                            bitcnt <= bitcnt + 3'd1;
                        end
                        if (byte_done) begin
                            state <= ST_ACK;
                            if (state == ST_DEV) begin
                                if (rx_byte[7:4] != DEV_PREFIX || rx_byte[3] != a2_strap) begin
                                    state <= ST_IDLE;
                                end else if (rx_byte[0]) begin
                                    cnt <= {rx_byte[BLK_W:1], cnt[7:0]};
                                    nxt <= ST_TX;
                                end else begin
                                    blk_q <= rx_byte[BLK_W:1];
                                    nxt   <= ST_WORD;
                                end
                            end else if (state == ST_WORD) begin
                                cnt <= {blk_q, rx_byte};
                                nxt <= ST_DATA;
                            end else begin
                                wr_addr <= cnt;
                                wr_data <= rx_byte;
                                pend    <= 1'b1;
                                cnt     <= cnt + ONE;
                                nxt     <= ST_HOLD;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            if (!ack_on) begin
                                sda_oe <= 1'b1;
                                ack_on <= 1'b1;
                            end else begin
                                ack_on <= 1'b0;
                                bitcnt <= '0;
                                state  <= nxt;
                                if (nxt == ST_TX) begin
                                    tx     <= rd_q;
                                    sda_oe <= ~rd_q[7];
                                    cnt    <= cnt + ONE;
                                end else begin
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                tx     <= {tx[6:0], 1'b0};
                                sda_oe <= ~tx[6];
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) more <= ~sda_s;
                        if (scl_fall) begin
                            if (more) begin
                                tx     <= rd_q;
                                sda_oe <= ~rd_q[7];
                                cnt    <= cnt + ONE;
                                bitcnt <= '0;
                                state  <= ST_TX;
                            end else begin
                                state <= ST_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: the pad drive moves only after an SCL fall or a bus condition.
    p_oe_after_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

    // R8: released while the master acknowledges read data.
    p_mack_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK) |-> !sda_oe);

    // R2, R7: idle after mismatch and hold after NACK keep SDA released.
    p_quiet_states_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_HOLD) |-> !sda_oe);

    // R1: a start always restarts address reception with SDA released.
    p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV && !sda_oe && bitcnt == 3'd0));

    // R3: the array is written only right after a stop.
    p_commit_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(stop_det));

    // R6: advancing past the top location continues at zero.
    p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && $past(state) == ST_MACK && $past(cnt) == {ADDR_W{1'b1}})
        |-> (cnt == '0));
endmodule

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic a2_tb = 1'b1;
    logic sda_oe;
    logic sda_line;
    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_eeprom_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .a2_strap(a2_tb), .sda_oe(sda_oe)
    );

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] rx_val;
    event       rx_ev;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    // Scoreboard monitor: compares each byte the master clocks in.
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) chk("unexpected byte", rx_val, 8'hxx);
            else chk(tag_q.pop_front(), rx_val, exp_q.pop_front());
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        summary();
    end

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b0; tk(Q); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        tk(Q); sda_m = 1'b0; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b1; tk(2*Q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        tk(Q); sda_m = b; tk(Q); scl_m = 1'b1; tk(Q); s = sda_line; tk(Q); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
        sda_m = 1'b1;
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] v, output logic s9);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(~m_ack, s9);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic [1:0] blk, input logic rw, input logic a2);
        return {4'b1010, a2, blk, rw};
    endfunction

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        logic ack;
        bus_start();
        send_byte(dev(a[9:8], 1'b0, a2_tb), ack); chk("R2 address ack", ack, 1'b1);
        send_byte(a[7:0], ack);                   chk("R3 word ack", ack, 1'b1);
        send_byte(d, ack);                        chk("R3 data ack", ack, 1'b1);
        bus_stop();
    endtask

    task automatic get_bytes(input int n);
        logic [7:0] v;
        logic s9;
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v, s9);
            rx_val = v;
            -> rx_ev;
            if (k == n - 1) chk("R8 released at NACK clock", s9, 1'b1);
        end
    endtask

    task automatic rnd_read(input logic [9:0] a, input int n, input bit fresh);
        logic ack;
        if (fresh) begin
            bus_start();
            send_byte(dev(a[9:8], 1'b0, a2_tb), ack); chk("R5 dummy write ack", ack, 1'b1);
        end
        send_byte(a[7:0], ack);                   chk("R5 word ack", ack, 1'b1);
        bus_start();
        send_byte(dev(a[9:8], 1'b1, a2_tb), ack); chk("R5 read address ack", ack, 1'b1);
        get_bytes(n);
        bus_stop();
    endtask

    task automatic cur_read(input logic [1:0] blk);
        logic ack;
        bus_start();
        send_byte(dev(blk, 1'b1, a2_tb), ack); chk("R4 read address ack", ack, 1'b1);
        get_bytes(1);
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic s;
        logic [7:0] v;
        tk(5);
        rst_n = 1'b1;
        tk(5);
        chk("R9 reset sda_oe", sda_oe, 1'b0);

        // R9: address pattern clocked without a start gets no ACK
        scl_m = 1'b0; tk(Q);
        send_byte(dev(2'd0, 1'b0, a2_tb), ack);
        chk("R9 no ack without start", ack, 1'b0);
        bus_stop();

        // R3: byte writes, committed at stop
        wr(10'h123, 8'hA5);
        wr(10'h124, 8'h11);
        wr(10'h3FE, 8'h5A);
        wr(10'h3FF, 8'hC3);
        wr(10'h000, 8'h3C);
        wr(10'h001, 8'h96);
        wr(10'h201, 8'h18);
        wr(10'h200, 8'hE7);

        // R4: current read after a write at 0x200 returns 0x201
        expect_byte(8'h18, "R4 current read after write");
        cur_read(2'd2);

        // R5: random read; then R4 current read continues at +1
        expect_byte(8'hA5, "R5 random read 0x123");
        rnd_read(10'h123, 1, 1'b1);
        expect_byte(8'h11, "R4 current read after read");
        cur_read(2'd1);

        // R3: write data followed by repeated start instead of stop is discarded
        bus_start();
        send_byte(dev(2'd1, 1'b0, a2_tb), ack); chk("R3 ack", ack, 1'b1);
        send_byte(8'h24, ack);                  chk("R3 ack", ack, 1'b1);
        send_byte(8'h77, ack);                  chk("R3 ack", ack, 1'b1);
        expect_byte(8'h11, "R3 no commit without stop");
        bus_start();
        send_byte(dev(2'd1, 1'b0, a2_tb), ack); chk("R3 ack", ack, 1'b1);
        rnd_read(10'h124, 1, 1'b0);

        // R6: sequential read across the top of the array
        expect_byte(8'h5A, "R6 seq 0x3FE");
        expect_byte(8'hC3, "R6 seq 0x3FF");
        expect_byte(8'h3C, "R6 seq wrap 0x000");
        expect_byte(8'h96, "R6 seq 0x001");
        rnd_read(10'h3FE, 4, 1'b1);

        // R7: after a NACK further clocks see SDA released
        bus_start();
        send_byte(dev(2'd1, 1'b0, a2_tb), ack); chk("R7 ack", ack, 1'b1);
        send_byte(8'h23, ack);                  chk("R7 ack", ack, 1'b1);
        bus_start();
        send_byte(dev(2'd1, 1'b1, a2_tb), ack); chk("R7 ack", ack, 1'b1);
        recv_byte(1'b0, v, s);                  chk("R7 data before nack", v, 8'hA5);
        recv_byte(1'b1, v, s);                  chk("R7 released after nack", v, 8'hFF);
        bus_stop();

        // R2: strap mismatch gets no ACK and leaves memory unchanged
        bus_start();
        send_byte(dev(2'd1, 1'b0, ~a2_tb), ack); chk("R2 mismatch no ack", ack, 1'b0);
        send_byte(8'h23, ack);                   chk("R2 mismatch word no ack", ack, 1'b0);
        send_byte(8'h00, ack);                   chk("R2 mismatch data no ack", ack, 1'b0);
        bus_stop();
        expect_byte(8'hA5, "R2 memory unchanged after mismatch");
        rnd_read(10'h123, 1, 1'b1);

        // R2: other strap value matches its own address bit
        a2_tb = 1'b0;
        wr(10'h050, 8'h42);
        expect_byte(8'h42, "R2 strap low access");
        rnd_read(10'h050, 1, 1'b1);
        a2_tb = 1'b1;

        // R1: start in the middle of an address byte restarts reception
        bus_start();
        for (int i = 0; i < 4; i++) clock_bit(1'b0, s);
        expect_byte(8'hC3, "R1 restart after abort");
        rnd_read(10'h3FF, 1, 1'b1);

        tk(40);
        chk("R6 scoreboard drained", 8'(exp_q.size()), 8'd0);
        summary();
    end
endmodule